// File: doc/BRIEF.md
# Configurable Fault Response Controller

This block takes a raw overcurrent fault indication and turns it into the system's reaction to it. A two-bit policy code chooses one of three reactions. In flag-only, the block reports the fault and switching goes on. In hiccup, switching halts and restarts by itself once the fault has been gone for a set time. In latch-off, switching halts until the enables are cycled. A selector input decides where the policy code comes from: the register field, or an external mode input.

The block has three outputs. The first is a sticky status bit, and software clears it with a write-one-to-clear pulse. The second is an active-low alert that follows the status bit. The third is a gate that allows or blocks PWM switching. The restart delay is a parameter counted in clock cycles. The raw fault passes through a two-flop synchroniser before any decision is taken on it.

Top module: `fault_response_ctrl`

## Requirements
- R1: The policy code is decoded as 2'b00 = flag only, 2'b01 = hiccup, 2'b10 = latch-off, and 2'b11 = flag only (same as 2'b00).
- R2: When `useRegPolicy` is 1, `regPolicy` sets the policy. When it is 0, `pinPolicy` (same encoding) sets it and `regPolicy` has no effect.
- R3: `faultRaw` passes through two synchronising flops. When it is high before rising edge k, `statusBit` is 1 and `alertN` is 0 after edge k+2, and not before.
- R4: Under the flag-only policy, a fault leaves `pwmGate` at 1.
- R5: Under the hiccup policy, `pwmGate` drops on the same edge that sets the status. Suppose `faultRaw` goes low before edge j. Then `pwmGate` returns to 1 after edge j+1+RESTART_CYCLES, so the delay counts from when the fault is removed.
- R6: If the synchronised fault comes back while the restart countdown runs, the countdown starts again from zero.
- R7: Under the latch-off policy, `pwmGate` stays 0 after the fault clears. An enable toggle means `pwmEnIn & chipEnIn` going from 0 to 1. If such a toggle comes while the synchronised fault is low, `pwmGate` is 1 after that edge. A toggle while the fault is still present leaves the block latched.
- R8: `statusBit` and `alertN` hold until a `statusClr` pulse arrives while the synchronised fault is low. A clear pulse while the fault is present has no effect.
- R9: After reset, `pwmGate` is 1, `statusBit` is 0 and `alertN` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultRaw | input | 1 | Raw fault indication, asynchronous |
| useRegPolicy | input | 1 | 1: take policy from register field; 0: from mode input |
| regPolicy | input | 2 | Register policy code |
| pinPolicy | input | 2 | Mode-input policy code |
| pwmEnIn | input | 1 | PWM enable input |
| chipEnIn | input | 1 | Chip enable input |
| statusClr | input | 1 | Write-one-to-clear pulse for the status bit |
| statusBit | output | 1 | Sticky fault status |
| alertN | output | 1 | Active-low alert |
| pwmGate | output | 1 | 1 allows PWM switching |

## Verification
Most state faults show up on `pwmGate` or `statusBit` within one to three cycles. A wrong response state or a wrong policy decode flips `pwmGate` on the edge after the synchronised fault is seen. A bad synchroniser shifts the status edge by a cycle. A bad restart counter shows only at the end of the countdown, RESTART_CYCLES edges after the fault is removed. For that reason the bench compares every cycle against a reference model and also runs exact-edge directed checks around the countdown and the enable toggles.

// File: rtl/frc_pkg.sv
package frc_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_HOLD  = 2'd1,
    ST_LATCH = 2'd2
  } frcState_e;

  localparam logic [1:0] POL_HICCUP = 2'b01;
  localparam logic [1:0] POL_LATCH  = 2'b10;

  typedef struct packed {
    logic timerClr;
    logic timerInc;
  } frcStrobe_t;

endpackage

// File: rtl/frc_datapath.sv
module frc_datapath
  import frc_pkg::*;
#(
  parameter int RESTART_CYCLES = 62_500_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultRaw,
  input  logic       statusClr,
  input  logic       pwmEnIn,
  input  logic       chipEnIn,
  input  frcStrobe_t strb,
  output logic       faultSync,
  output logic       timerDone,
  output logic       enRise,
  output logic       statusBit
);

  localparam int CW = $clog2(RESTART_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(RESTART_CYCLES - 1);

  logic [SYNC_STAGES-1:0] syncPipe;
  logic [CW-1:0]          timerCnt;
  logic                   enNow;
  logic                   enPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= '0;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], faultRaw};
  end
  assign faultSync = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       statusBit <= 1'b0;
    else if (faultSync)              statusBit <= 1'b1;
    else if (statusClr)              statusBit <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              timerCnt <= '0;
    else if (strb.timerClr) timerCnt <= '0;
    else if (strb.timerInc) timerCnt <= timerCnt + 1'b1;
  end
  assign timerDone = (timerCnt == LAST);

  assign enNow = pwmEnIn & chipEnIn;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enPrev <= 1'b1;
    else       enPrev <= enNow;
  end
  assign enRise = enNow & ~enPrev;

  // R3
  fault_sets_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    faultSync |=> statusBit);

  // R8
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusBit && !statusClr) |=> statusBit);

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    timerCnt <= LAST);

endmodule

// File: rtl/frc_control.sv
module frc_control
  import frc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultSync,
  input  logic       timerDone,
  input  logic       enRise,
  input  logic       useRegPolicy,
  input  logic [1:0] regPolicy,
  input  logic [1:0] pinPolicy,
  output frcStrobe_t strb,
  output logic       pwmGate
);

  frcState_e  state;
  frcState_e  nextState;
  logic [1:0] effPolicy;
  logic       isHiccup;
  logic       isLatch;

  assign effPolicy = useRegPolicy ? regPolicy : pinPolicy;
  assign isHiccup  = (effPolicy == POL_HICCUP);
  assign isLatch   = (effPolicy == POL_LATCH);

  always_comb begin
    nextState = state;
    case (state)
      ST_RUN: begin
        if (faultSync) begin
          if (isHiccup)     nextState = ST_HOLD;
          else if (isLatch) nextState = ST_LATCH;
        end
      end
      ST_HOLD:  if (!faultSync && timerDone) nextState = ST_RUN;
      ST_LATCH: if (enRise && !faultSync)    nextState = ST_RUN;
      default:  nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    strb.timerClr = (state != ST_HOLD) || faultSync;
    strb.timerInc = (state == ST_HOLD) && !faultSync && !timerDone;
  end

  assign pwmGate = (state == ST_RUN);

  // R4
  flag_keeps_pwm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && faultSync && !isHiccup && !isLatch) |=> pwmGate);

  // R6
  hiccup_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && faultSync) |=> (state == ST_HOLD));

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCH && !(enRise && !faultSync)) |=> !pwmGate);

endmodule

// File: rtl/fault_response_ctrl.sv
module fault_response_ctrl
  import frc_pkg::*;
#(
  parameter int RESTART_CYCLES = 62_500_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       faultRaw,
  input  logic       useRegPolicy,
  input  logic [1:0] regPolicy,
  input  logic [1:0] pinPolicy,
  input  logic       pwmEnIn,
  input  logic       chipEnIn,
  input  logic       statusClr,
  output logic       statusBit,
  output logic       alertN,
  output logic       pwmGate
);

  frcStrobe_t strb;
  logic       faultSync;
  logic       timerDone;
  logic       enRise;

  frc_datapath #(
    .RESTART_CYCLES(RESTART_CYCLES),
    .SYNC_STAGES   (2)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .faultRaw (faultRaw),
    .statusClr(statusClr),
    .pwmEnIn  (pwmEnIn),
    .chipEnIn (chipEnIn),
    .strb     (strb),
    .faultSync(faultSync),
    .timerDone(timerDone),
    .enRise   (enRise),
    .statusBit(statusBit)
  );

  frc_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .faultSync   (faultSync),
    .timerDone   (timerDone),
    .enRise      (enRise),
    .useRegPolicy(useRegPolicy),
    .regPolicy   (regPolicy),
    .pinPolicy   (pinPolicy),
    .strb        (strb),
    .pwmGate     (pwmGate)
  );

  assign alertN = ~statusBit;

endmodule

// File: tb/fault_response_ctrl_bench.sv
module fault_response_ctrl_bench;

  localparam int D = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic faultRaw = 1'b0;
  logic useRegPolicy = 1'b1;
  logic [1:0] regPolicy = 2'b00;
  logic [1:0] pinPolicy = 2'b00;
  logic pwmEnIn = 1'b1;
  logic chipEnIn = 1'b1;
  logic statusClr = 1'b0;
  logic statusBit, alertN, pwmGate;

  int nChk = 0;
  int nBad = 0;
  bit cmpOn = 1'b0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  fault_response_ctrl #(.RESTART_CYCLES(D)) u_fault_response_ctrl (
    .clk(clk), .rstN(rstN), .faultRaw(faultRaw), .useRegPolicy(useRegPolicy),
    .regPolicy(regPolicy), .pinPolicy(pinPolicy), .pwmEnIn(pwmEnIn),
    .chipEnIn(chipEnIn), .statusClr(statusClr), .statusBit(statusBit),
    .alertN(alertN), .pwmGate(pwmGate)
  );

  // Reference model: 0 run, 1 waiting for restart, 2 latched
  logic [1:0] mSync;
  logic       mStatus, mPrevEn;
  int         mMode, mCnt;

  function automatic int policyOf(logic useReg, logic [1:0] r, logic [1:0] p);
    logic [1:0] c = useReg ? r : p;
    if (c == 2'b01) return 1;
    if (c == 2'b10) return 2;
    return 0;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSync <= 2'b00; mStatus <= 1'b0; mPrevEn <= 1'b1; mMode <= 0; mCnt <= 0;
    end else begin
      logic f, en;
      f  = mSync[1];
      en = pwmEnIn & chipEnIn;
      mSync   <= {mSync[0], faultRaw};
      mPrevEn <= en;
      if (f) mStatus <= 1'b1;
      else if (statusClr) mStatus <= 1'b0;
      case (mMode)
        0: if (f) begin mMode <= policyOf(useRegPolicy, regPolicy, pinPolicy); mCnt <= 0; end
        1: if (f) mCnt <= 0;
           else if (mCnt == D - 1) mMode <= 0;
           else mCnt <= mCnt + 1;
        default: if (en && !mPrevEn && !f) mMode <= 0;
      endcase
    end
  end

  task automatic check(string tag, logic got, logic exp, string what);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmpOn && !finished) begin
      check("R8", statusBit, mStatus, "model statusBit");
      check("R3", alertN, ~mStatus, "model alertN");
      check(mMode == 1 ? "R5" : (mMode == 2 ? "R7" : "R4"), pwmGate, mMode == 0, "model pwmGate");
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearStatus();
    statusClr = 1'b1; tick(1); statusClr = 1'b0;
  endtask

  initial begin
    int wd = 0;
    while (!finished && wd < 150000) begin @(posedge clk); wd++; end
    if (!finished) begin
      finished = 1'b1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R9 reset state
    check("R9", pwmGate, 1'b1, "reset pwmGate");
    check("R9", statusBit, 1'b0, "reset statusBit");
    check("R9", alertN, 1'b1, "reset alertN");
    cmpOn = 1'b1;

    // R3 synchroniser latency, R4 flag only, R8 clear behaviour
    regPolicy = 2'b00; faultRaw = 1'b1;
    tick(2); check("R3", statusBit, 1'b0, "status before sync");
    tick(1); check("R3", statusBit, 1'b1, "status after sync");
    check("R3", alertN, 1'b0, "alert after sync");
    check("R4", pwmGate, 1'b1, "flag keeps pwm");
    clearStatus(); tick(1);
    check("R8", statusBit, 1'b1, "clear ignored while fault");
    faultRaw = 1'b0; tick(3);
    check("R8", statusBit, 1'b1, "status sticky");
    clearStatus();
    check("R8", statusBit, 1'b0, "clear after fault gone");
    check("R8", alertN, 1'b1, "alert released");

    // R1 code 11 acts as flag only
    regPolicy = 2'b11; faultRaw = 1'b1; tick(4);
    check("R1", pwmGate, 1'b1, "code 11 flag only");
    faultRaw = 1'b0; tick(3); clearStatus();

    // R5 hiccup timing from fault removal
    regPolicy = 2'b01; faultRaw = 1'b1; tick(3);
    check("R5", pwmGate, 1'b0, "hiccup stops pwm");
    tick(5); faultRaw = 1'b0;
    tick(D + 1); check("R5", pwmGate, 1'b0, "hiccup before delay");
    tick(1);     check("R5", pwmGate, 1'b1, "hiccup restart");

    // R6 retrigger during countdown
    faultRaw = 1'b1; tick(3); faultRaw = 1'b0; tick(6);
    faultRaw = 1'b1; tick(1); faultRaw = 1'b0;
    tick(D + 1); check("R6", pwmGate, 1'b0, "countdown restarted");
    tick(1);     check("R6", pwmGate, 1'b1, "restart after retrigger");
    clearStatus();

    // R7 latch-off
    regPolicy = 2'b10; faultRaw = 1'b1; tick(3);
    faultRaw = 1'b0; tick(10);
    check("R7", pwmGate, 1'b0, "latched after fault gone");
    faultRaw = 1'b1; tick(3);
    pwmEnIn = 1'b0; tick(1); pwmEnIn = 1'b1; tick(1);
    check("R7", pwmGate, 1'b0, "toggle during fault ignored");
    faultRaw = 1'b0; tick(4);
    pwmEnIn = 1'b0; tick(1); pwmEnIn = 1'b1; tick(1);
    check("R7", pwmGate, 1'b1, "toggle re-enables");
    clearStatus();

    // R2 pin policy selection
    useRegPolicy = 1'b0; pinPolicy = 2'b00; regPolicy = 2'b10;
    faultRaw = 1'b1; tick(4);
    check("R2", pwmGate, 1'b1, "register code ignored");
    faultRaw = 1'b0; tick(3);
    pinPolicy = 2'b10; faultRaw = 1'b1; tick(3);
    check("R2", pwmGate, 1'b0, "pin latch policy");
    faultRaw = 1'b0; tick(4);
    chipEnIn = 1'b0; tick(1); chipEnIn = 1'b1; tick(1);
    check("R7", pwmGate, 1'b1, "chip enable toggle");
    clearStatus();

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 25 == 0) faultRaw = ~faultRaw;
      if ($urandom % 60 == 0) regPolicy = 2'($urandom);
      if ($urandom % 60 == 0) pinPolicy = 2'($urandom);
      if ($urandom % 90 == 0) useRegPolicy = ~useRegPolicy;
      statusClr = ($urandom % 8 == 0);
      pwmEnIn  = ($urandom % 30 != 0);
      chipEnIn = ($urandom % 50 != 0);
      tick(1);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule